// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This block copies data from card-side memory to host-side memory by following a chain of descriptors that software has laid out in one contiguous array. Software writes the address of the first descriptor, pulses a start strobe, and the engine fetches each descriptor in turn through a single word-wide memory port. It validates each descriptor and copies the requested number of bytes one 32-bit word at a time, reading then writing each word. It stops at the descriptor that carries the last flag.

When the chain ends, whether normally or through an error, the engine records the outcome in a sticky five-bit status register. It also raises a level interrupt that stays high until software acknowledges it. A chain that never sets the last flag is cut off after a parameterised number of descriptors and is reported as an array fault.

Top module: `sgm_chain_mover`

## Requirements
- R1: A descriptor is three 32-bit words at the descriptor address plus 0, 4 and 8: source address, destination address, control. In the control word, bits 15:0 are the byte count, bit 31 is the last flag, and bits 30:16 have no effect.
- R2: A valid descriptor moves count/4 words. For each word the engine reads the source address and then writes that word to the destination address, and both addresses advance by 4 per word.
- R3: On the memory port, `mem_req` stays asserted with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`, and every address is a multiple of 4.
- R4: The next descriptor lies 12 bytes after the current one. Finishing a descriptor whose last flag is set sets status bits 0 (read done) and 1 (write done) and raises `irq_o`. No interrupt is raised while the chain is still running.
- R5: A count that is zero, or that has any of bits 7:0 set, sets status bit 4 (array fault), ends the chain without moving any word of that descriptor, and raises `irq_o`.
- R6: An error response to a data read sets status bit 2 (read fault) and ends the chain without writing that word. An error response to a descriptor fetch sets bit 4. Both raise `irq_o`.
- R7: An error response to a data write sets status bit 3 (write fault), ends the chain and raises `irq_o`.
- R8: If MAX_DESC descriptors complete without a last flag, the engine stops, sets status bit 4 and raises `irq_o`, having copied the data of all MAX_DESC descriptors.
- R9: Status bits are sticky across chains. A cycle with `stat_clr_en` high clears exactly the bits set in `stat_clr_mask`.
- R10: `irq_o` is a level that stays high until a cycle with `irq_ack` high clears it. Acknowledging leaves the status unchanged.
- R11: `busy` is high from the cycle after an accepted start until the chain ends. A start pulse while busy is ignored, and the memory port is quiet while idle.
- R12: After reset, status, `irq_o`, `busy` and `mem_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse |
| desc_base | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| stat_o | output | 5 | Sticky status: 0 rd done, 1 wr done, 2 rd fault, 3 wr fault, 4 array fault |
| stat_clr_en | input | 1 | Write-one-to-clear strobe |
| stat_clr_mask | input | 5 | Status bits to clear |
| irq_o | output | 1 | Completion interrupt level |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; rdata and err valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Error response for this access |

## Verification
The bench targets counts that are zero or not a multiple of 256. A design that accepted them would copy stray words or hang on a zero count. It places faults on the first data read, on a mid-chain write and on a descriptor fetch. A design that mixed up the fault bits or kept running after a fault would leave the wrong destination image. It runs a chain with no last flag, where a design without the limit would walk off the array, and it pulses start mid-chain, where a design that restarted would copy a second region. Random chains and random memory latency check that the word order and address stepping hold under stalls.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
   localparam int unsigned ST_W       = 5;
   localparam int unsigned ST_RD_DONE = 0;
   localparam int unsigned ST_WR_DONE = 1;
   localparam int unsigned ST_RD_ERR  = 2;
   localparam int unsigned ST_WR_ERR  = 3;
   localparam int unsigned ST_ARR_ERR = 4;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned LAST_BIT   = 31;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_NEXT
   } seq_state_t;
endpackage

// File: rtl/sgm_desc_check.sv
module sgm_desc_check #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned UNIT_LOG2 = 8
) (
   input  logic [31:0]      ctrl_i,
   output logic             ok_o,
   output logic             last_o,
   output logic [CNT_W-3:0] words_o
);
   import sgm_pkg::*;
   logic [CNT_W-1:0] bytes;
   logic             unused_rsvd;

   if (CNT_W < UNIT_LOG2 + 1 || CNT_W > 31) begin : g_bad_cnt
      $error("sgm_desc_check: CNT_W out of range");
   end
   if (UNIT_LOG2 < 2) begin : g_bad_unit
      $error("sgm_desc_check: unit must hold whole words");
   end

   assign bytes       = ctrl_i[CNT_W-1:0];
   assign unused_rsvd = ^ctrl_i[LAST_BIT-1:CNT_W];
   assign last_o      = ctrl_i[LAST_BIT];
   assign ok_o        = (bytes != '0) && (bytes[UNIT_LOG2-1:0] == '0);
   assign words_o     = bytes[CNT_W-1:2];
endmodule

// File: rtl/sgm_status.sv
module sgm_status #(
   parameter int unsigned NBITS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [NBITS-1:0] clr_mask_i,
   input  logic             irq_set_i,
   input  logic             irq_ack_i,
   output logic [NBITS-1:0] stat_o,
   output logic             irq_o
);
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        stat_o[b] <= 1'b0;
         else if (set_i[b])                 stat_o[b] <= 1'b1;
         else if (clr_en_i && clr_mask_i[b]) stat_o[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_o <= 1'b0;
      else if (irq_set_i) irq_o <= 1'b1;
      else if (irq_ack_i) irq_o <= 1'b0;
   end
endmodule

// File: rtl/sgm_seq.sv
module sgm_seq #(
   parameter int unsigned MAX_DESC  = 16,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned UNIT_LOG2 = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go_i,
   input  logic [31:0]            base_i,
   output logic                   busy_o,
   output logic                   mem_req_o,
   output logic                   mem_we_o,
   output logic [31:0]            mem_addr_o,
   output logic [31:0]            mem_wdata_o,
   input  logic                   mem_ack_i,
   input  logic [31:0]            mem_rdata_i,
   input  logic                   mem_err_i,
   output logic [sgm_pkg::ST_W-1:0] set_o,
   output logic                   irq_set_o
);
   import sgm_pkg::*;
   localparam int unsigned NDW    = $clog2(MAX_DESC) + 1;
   localparam int unsigned WLW    = CNT_W - 2;
   localparam logic [31:0] STRIDE = 32'd12;

   seq_state_t     state;
   logic [31:0]    ptr, src, dst, ctrl, dbuf;
   logic [1:0]     fidx;
   logic [WLW-1:0] wleft;
   logic [NDW-1:0] ndesc;
   logic           d_ok, d_last;
   logic [WLW-1:0] d_words;

   sgm_desc_check #(.CNT_W(CNT_W), .UNIT_LOG2(UNIT_LOG2)) u_chk (
      .ctrl_i (ctrl),
      .ok_o   (d_ok),
      .last_o (d_last),
      .words_o(d_words)
   );

   assign busy_o      = (state != S_IDLE);
   assign mem_req_o   = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE);
   assign mem_we_o    = (state == S_WRITE);
   assign mem_wdata_o = dbuf;

   always_comb begin
      unique case (state)
         S_FETCH: mem_addr_o = ptr + {28'd0, fidx, 2'b00};
         S_READ:  mem_addr_o = src;
         S_WRITE: mem_addr_o = dst;
         default: mem_addr_o = '0;
      endcase
   end

   // outcome pulses towards the status register
   always_comb begin
      set_o     = '0;
      irq_set_o = 1'b0;
      unique case (state)
         S_FETCH: if (mem_ack_i && mem_err_i) begin
            set_o[ST_ARR_ERR] = 1'b1; irq_set_o = 1'b1;
         end
         S_CHECK: if (!d_ok) begin
            set_o[ST_ARR_ERR] = 1'b1; irq_set_o = 1'b1;
         end
         S_READ: if (mem_ack_i && mem_err_i) begin
            set_o[ST_RD_ERR] = 1'b1; irq_set_o = 1'b1;
         end
         S_WRITE: if (mem_ack_i && mem_err_i) begin
            set_o[ST_WR_ERR] = 1'b1; irq_set_o = 1'b1;
         end
         S_NEXT: begin
            if (d_last) begin
               set_o[ST_RD_DONE] = 1'b1;
               set_o[ST_WR_DONE] = 1'b1;
               irq_set_o         = 1'b1;
            end else if (ndesc == NDW'(MAX_DESC - 1)) begin
               set_o[ST_ARR_ERR] = 1'b1;
               irq_set_o         = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         ptr   <= '0;
         src   <= '0;
         dst   <= '0;
         ctrl  <= '0;
         dbuf  <= '0;
         fidx  <= '0;
         wleft <= '0;
         ndesc <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (go_i) begin
               ptr   <= base_i;
               ndesc <= '0;
               fidx  <= '0;
               state <= S_FETCH;
            end
            S_FETCH: if (mem_ack_i) begin
               if (mem_err_i) state <= S_IDLE;
               else begin
                  unique case (fidx)
                     2'd0:    src  <= mem_rdata_i;
                     2'd1:    dst  <= mem_rdata_i;
                     default: ctrl <= mem_rdata_i;
                  endcase
                  if (fidx == 2'd2) state <= S_CHECK;
                  else              fidx  <= fidx + 2'd1;
               end
            end
            S_CHECK: begin
               wleft <= d_words;
               state <= d_ok ? S_READ : S_IDLE;
            end
            S_READ: if (mem_ack_i) begin
               dbuf  <= mem_rdata_i;
               state <= mem_err_i ? S_IDLE : S_WRITE;
            end
            S_WRITE: if (mem_ack_i) begin
               if (mem_err_i) state <= S_IDLE;
               else begin
                  src   <= src + 32'd4;
                  dst   <= dst + 32'd4;
                  wleft <= wleft - 1'b1;
                  state <= (wleft == WLW'(1)) ? S_NEXT : S_READ;
               end
            end
            S_NEXT: begin
               if (d_last || ndesc == NDW'(MAX_DESC - 1)) state <= S_IDLE;
               else begin
                  ndesc <= ndesc + 1'b1;
                  ptr   <= ptr + STRIDE;
                  fidx  <= '0;
                  state <= S_FETCH;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sgm_chain_mover.sv
module sgm_chain_mover #(
   parameter int unsigned MAX_DESC  = 16,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned UNIT_LOG2 = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic [31:0] desc_base,
   output logic        busy,
   output logic [4:0]  stat_o,
   input  logic        stat_clr_en,
   input  logic [4:0]  stat_clr_mask,
   output logic        irq_o,
   input  logic        irq_ack,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   input  logic        mem_err
);
   import sgm_pkg::*;
   logic [ST_W-1:0] st_set;
   logic            irq_set;

   if (MAX_DESC < 1) begin : g_bad_max
      $error("sgm_chain_mover: MAX_DESC must be at least 1");
   end
   if (ST_W != 5) begin : g_bad_stw
      $error("sgm_chain_mover: status width mismatch");
   end

   sgm_seq #(.MAX_DESC(MAX_DESC), .CNT_W(CNT_W), .UNIT_LOG2(UNIT_LOG2)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .base_i     (desc_base),
      .busy_o     (busy),
      .mem_req_o  (mem_req),
      .mem_we_o   (mem_we),
      .mem_addr_o (mem_addr),
      .mem_wdata_o(mem_wdata),
      .mem_ack_i  (mem_ack),
      .mem_rdata_i(mem_rdata),
      .mem_err_i  (mem_err),
      .set_o      (st_set),
      .irq_set_o  (irq_set)
   );

   sgm_status #(.NBITS(ST_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (st_set),
      .clr_en_i  (stat_clr_en),
      .clr_mask_i(stat_clr_mask),
      .irq_set_i (irq_set),
      .irq_ack_i (irq_ack),
      .stat_o    (stat_o),
      .irq_o     (irq_o)
   );
endmodule

// File: rtl/sgm_chain_mover_chk.sv
module sgm_chain_mover_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic [4:0]  stat_o,
   input logic        stat_clr_en,
   input logic        irq_o,
   input logic        irq_ack,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack
);
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !irq_ack |=> irq_o);

   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr_en |=> (stat_o & $past(stat_o)) == $past(stat_o));

   p_irq_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> !busy);

   p_done_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[0]) |-> irq_o && stat_o[1]);
endmodule

bind sgm_chain_mover sgm_chain_mover_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .stat_o     (stat_o),
   .stat_clr_en(stat_clr_en),
   .irq_o      (irq_o),
   .irq_ack    (irq_ack),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack)
);

// File: tb/sgm_chain_mover_bench.sv
module sgm_chain_mover_bench;
   localparam int MAXD = 4;
   localparam logic [31:0] NO_ERR = 32'hFFFF_FFFC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [31:0] desc_base = '0;
   logic        busy;
   logic [4:0]  stat_o;
   logic        stat_clr_en = 1'b0;
   logic [4:0]  stat_clr_mask = '0;
   logic        irq_o;
   logic        irq_ack = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   logic [31:0] mem [1024];
   logic [31:0] exp_mem [1024];
   logic [4:0]  exp_stat = '0;
   logic [31:0] err_addr = NO_ERR;
   int          n_chk = 0, n_fail = 0, irq_busy = 0, cyc = 0, wait_cnt = 0;

   always #10 clk = ~clk;

   sgm_chain_mover #(.MAX_DESC(MAXD)) u_sgm_chain_mover (
      .clk(clk), .rst_n(rst_n), .go(go), .desc_base(desc_base), .busy(busy),
      .stat_o(stat_o), .stat_clr_en(stat_clr_en), .stat_clr_mask(stat_clr_mask),
      .irq_o(irq_o), .irq_ack(irq_ack), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   always @(negedge clk) if (busy && irq_o) irq_busy = irq_busy + 1;

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
         end else if (mem_req) begin
            if (wait_cnt == 0) begin
               mem_ack = 1'b1;
               mem_err = (mem_addr == err_addr);
               if (!mem_err) begin
                  if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                  else        mem_rdata = mem[mem_addr[11:2]];
               end
               wait_cnt = $urandom % 3;
            end else wait_cnt = wait_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // bench model of a chain run, built from the requirements
   task automatic model_run(input logic [31:0] base);
      logic [31:0] p, s, t;
      logic [31:0] w [3];
      logic [15:0] cnt;
      exp_mem = mem;
      p = base;
      for (int d = 0; d < MAXD; d++) begin
         for (int k = 0; k < 3; k++) begin
            if (p + 32'(4 * k) == err_addr) begin exp_stat |= 5'h10; return; end
            w[k] = exp_mem[(p[11:2] + 10'(k))];
         end
         cnt = w[2][15:0];
         if (cnt == 0 || cnt[7:0] != 0) begin exp_stat |= 5'h10; return; end
         s = w[0]; t = w[1];
         for (int i = 0; i < int'(cnt) / 4; i++) begin
            if (s == err_addr) begin exp_stat |= 5'h04; return; end
            if (t == err_addr) begin exp_stat |= 5'h08; return; end
            exp_mem[t[11:2]] = exp_mem[s[11:2]];
            s = s + 4; t = t + 4;
         end
         if (w[2][31]) begin exp_stat |= 5'h03; return; end
         p = p + 12;
      end
      exp_stat |= 5'h10;
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] s,
                           input logic [31:0] t, input logic [31:0] c);
      mem[a[11:2]] = s;
      mem[a[11:2] + 10'd1] = t;
      mem[a[11:2] + 10'd2] = c;
   endtask

   task automatic prep_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 256; i < 512; i++) mem[i] = $urandom;
      for (int i = 512; i < 1024; i++) mem[i] = '0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      stat_clr_en = 1'b1; stat_clr_mask = 5'h1F; irq_ack = 1'b1;
      @(negedge clk);
      stat_clr_en = 1'b0; stat_clr_mask = '0; irq_ack = 1'b0;
      exp_stat = '0;
   endtask

   task automatic run_chain(input logic [31:0] base, input string req);
      int bad;
      model_run(base);
      @(negedge clk);
      go = 1'b1; desc_base = base;
      @(negedge clk);
      go = 1'b0;
      chk(busy == 1'b1, req, "busy after start", busy, 1);
      while (busy) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, req, "memory image mismatching words", bad, 0);
      chk(stat_o == exp_stat, req, "status", stat_o, exp_stat);
      chk(irq_o == 1'b1, req, "irq at end", irq_o, 1);
   endtask

   initial begin
      logic [31:0] s, t;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(stat_o == 0, "R12", "status", stat_o, 0);
      chk(irq_o == 0, "R12", "irq", irq_o, 0);
      chk(busy == 0, "R12", "busy", busy, 0);
      chk(mem_req == 0, "R12", "mem_req", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: single descriptor, reserved bits set, last flag
      prep_mem();
      put_desc(32'h0, 32'h400, 32'h800, 32'hFFFF_0100);
      run_chain(32'h0, "R1");
      chk(stat_o == 5'h03, "R2", "done bits", stat_o, 5'h03);

      // R10: ack clears irq, status kept
      @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk(irq_o == 0, "R10", "irq after ack", irq_o, 0);
      chk(stat_o == 5'h03, "R10", "status kept after ack", stat_o, 5'h03);
      // R9: write-one-to-clear per bit
      @(negedge clk); stat_clr_en = 1'b1; stat_clr_mask = 5'h01;
      @(negedge clk); stat_clr_en = 1'b0; stat_clr_mask = '0;
      chk(stat_o == 5'h02, "R9", "only bit0 cleared", stat_o, 5'h02);
      clear_all();

      // R4: three-descriptor chain, no irq mid-chain
      prep_mem();
      irq_busy = 0;
      put_desc(32'h0, 32'h400, 32'h800, 32'h0000_0200);
      put_desc(32'hC, 32'h600, 32'hA00, 32'h0000_0100);
      put_desc(32'h18, 32'h700, 32'hC00, 32'h8000_0100);
      run_chain(32'h0, "R4");
      chk(irq_busy == 0, "R4", "irq cycles while busy", irq_busy, 0);
      clear_all();

      // R5: unaligned count, then zero count
      prep_mem();
      put_desc(32'h0, 32'h400, 32'h800, 32'h8000_0180);
      run_chain(32'h0, "R5");
      clear_all();
      put_desc(32'h0, 32'h400, 32'h800, 32'h8000_0100);
      put_desc(32'hC, 32'h400, 32'h900, 32'h8000_0000);
      mem[2] = 32'h0000_0100;
      run_chain(32'h0, "R5");
      clear_all();

      // R6: read fault on the first word, then descriptor fetch fault
      prep_mem();
      put_desc(32'h0, 32'h400, 32'h800, 32'h8000_0100);
      err_addr = 32'h400;
      run_chain(32'h0, "R6");
      chk(stat_o == 5'h04, "R6", "read fault bit", stat_o, 5'h04);
      // R9: sticky across a following good chain
      err_addr = NO_ERR;
      @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      run_chain(32'h0, "R9");
      chk(stat_o == 5'h07, "R9", "sticky accumulate", stat_o, 5'h07);
      clear_all();
      err_addr = 32'h10;
      put_desc(32'h0, 32'h400, 32'h800, 32'h0000_0100);
      run_chain(32'h0, "R6");
      chk(stat_o == 5'h10, "R6", "fetch fault bit", stat_o, 5'h10);
      clear_all();

      // R7: write fault mid-chain
      prep_mem();
      put_desc(32'h0, 32'h400, 32'h800, 32'h0000_0100);
      put_desc(32'hC, 32'h500, 32'h900, 32'h8000_0100);
      err_addr = 32'h940;
      run_chain(32'h0, "R7");
      chk(stat_o == 5'h08, "R7", "write fault bit", stat_o, 5'h08);
      err_addr = NO_ERR;
      clear_all();

      // R8: no last flag, limit reached
      prep_mem();
      for (int d = 0; d < MAXD + 1; d++)
         put_desc(32'(12 * d), 32'h400 + 32'(256 * d), 32'h800 + 32'(256 * d), 32'h0000_0100);
      run_chain(32'h0, "R8");
      chk(stat_o == 5'h10, "R8", "limit fault", stat_o, 5'h10);
      clear_all();

      // R11: start while busy is ignored
      prep_mem();
      put_desc(32'h0, 32'h400, 32'h800, 32'h8000_0300);
      put_desc(32'h80, 32'h400, 32'hE00, 32'h8000_0100);
      model_run(32'h0);
      @(negedge clk); go = 1'b1; desc_base = 32'h0;
      @(negedge clk); go = 1'b0;
      repeat (40) @(negedge clk);
      go = 1'b1; desc_base = 32'h80;
      @(negedge clk); go = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(busy == 0, "R11", "idle after chain", busy, 0);
      chk(mem[32'hE00 >> 2] === exp_mem[32'hE00 >> 2] && mem[32'hE00 >> 2] == 0,
          "R11", "second region untouched", mem[32'hE00 >> 2], 0);
      chk(stat_o == 5'h03, "R11", "status", stat_o, 5'h03);
      clear_all();

      // R2 R4: random chains with random faults
      for (int tr = 0; tr < 20; tr++) begin
         int n, left, units;
         prep_mem();
         n = 1 + ($urandom % 3);
         left = 4;
         s = 32'h400; t = 32'h800;
         for (int d = 0; d < n; d++) begin
            units = (d == n - 1) ? left : 1 + ($urandom % (left - (n - 1 - d)));
            if (units > 2) units = 2;
            put_desc(32'(12 * d), s, t, ((d == n - 1) ? 32'h8000_0000 : 32'h0) | 32'(units * 256));
            s = s + 32'(units * 256); t = t + 32'(units * 256);
            left = left - units;
         end
         if ($urandom % 10 < 3)
            err_addr = (($urandom % 2) ? 32'h400 : 32'h800) + 32'(4 * ($urandom % 64));
         else err_addr = NO_ERR;
         run_chain(32'h0, "R2");
         err_addr = NO_ERR;
         clear_all();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule